// File: doc/BRIEF.md
# Conditional Relative Branch Unit

This block works out the next value of a 64-bit instruction register for a family of jump instructions. Operand fetch, addressing-mode decode and the default increment of the instruction register happen elsewhere. This block receives the opcode, a 2-bit size code, the already-fetched destination and source operands, the 64-bit flag register and the current instruction register. It returns a taken indication together with the instruction register value to load.

There are two kinds of jump. A relative jump keeps only the low 1, 2, 4 or 8 bytes of the destination operand, as chosen by the size code. It sign-extends them and adds them to the current value, wrapping modulo 2^64. An absolute jump loads the whole destination operand. A jump is taken in one of four cases: always; on the state of the equal flag; when the source operand is non-zero; or on one of four user flags, chosen at run time by the low two bits of the source operand.

The block is purely combinational. It has no clock and no reset, so its outputs follow its inputs in the same cycle.

Top module: `relbr_unit`

## Requirements
- R1: Size code 00, 01, 10 and 11 select the low 8, 16, 32 and 64 bits of the destination operand as the offset. The offset is sign-extended to 64 bits, and destination bits above the selected width have no effect.
- R2: Opcode 0x03C is always taken, and the next value is the current value plus the offset.
- R3: Opcode 0x03D is taken only when flag bit 10 (equal) is 1. Opcode 0x03E is taken only when that bit is 0. When taken, both add the offset.
- R4: Opcode 0x03F is taken only when any bit of the full 64-bit source operand is 1. When taken, it adds the offset.
- R5: The user flag index is the source operand's bits [1:0]. Index 0, 1, 2 and 3 read flag bits 20, 21, 22 and 23.
- R6: Opcode 0x042, when the selected user flag is 1, outputs the full destination operand as the next value, independent of the size code.
- R7: Opcode 0x043, when the selected user flag is 1, outputs the current value plus the offset.
- R8: The relative sum wraps modulo 2^64, in both directions, and raises no indication.
- R9: When the condition is false, or the opcode is none of the six above (for example 0x040 or 0x03B), the taken output is 0 and the next value equals the current value.
- R10: The outputs respond to an input change without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 9 | Instruction opcode |
| size_i | input | 2 | Offset width code |
| dst_i | input | 64 | Destination operand (offset or absolute target) |
| src_i | input | 64 | Source operand (condition value or user flag index) |
| flags_i | input | 64 | Flag register |
| ir_i | input | 64 | Current instruction register |
| take_o | output | 1 | Jump taken |
| ir_next_o | output | 64 | Instruction register value to load |

## Verification
For each size code, the relative path is tried with a positive and a negative offset, and the destination bits above the chosen width are filled with junk. A wrong width or a wrong sign bit therefore gives a distinct sum. Each conditional opcode is tried with its condition true and with it false. The source-non-zero case uses a value whose only set bit is the top bit, which tells a full-width test from a truncated one. The user-flag opcodes are swept over all four indices with a single flag set, and a source operand with high junk bits checks that only the index bits matter. Sums that cross zero in both directions check the wrap. Non-branch opcodes are checked to leave the register untouched.

// File: rtl/relbr_pkg.sv
package relbr_pkg;

    localparam int OP_W     = 9;
    localparam int DATA_W   = 64;
    localparam int SZ_W     = 2;
    localparam int NUM_SZ   = 1 << SZ_W;
    localparam int EQ_BIT   = 10;
    localparam int UF_BASE  = 20;
    localparam int UF_IDX_W = 2;
    localparam int NUM_UF   = 1 << UF_IDX_W;

    localparam logic [OP_W-1:0] OPC_JREL    = 9'h03C;
    localparam logic [OP_W-1:0] OPC_JREL_EQ = 9'h03D;
    localparam logic [OP_W-1:0] OPC_JREL_NE = 9'h03E;
    localparam logic [OP_W-1:0] OPC_JREL_NZ = 9'h03F;
    localparam logic [OP_W-1:0] OPC_JABS_UF = 9'h042;
    localparam logic [OP_W-1:0] OPC_JREL_UF = 9'h043;

    typedef enum logic [2:0] {
        C_NEVER  = 3'd0,
        C_ALWAYS = 3'd1,
        C_EQ_SET = 3'd2,
        C_EQ_CLR = 3'd3,
        C_SRC_NZ = 3'd4,
        C_UFLAG  = 3'd5
    } cond_e;

    typedef struct packed {
        cond_e cond;
        logic  absolute;
    } br_ctl_t;

    function automatic br_ctl_t decode_op(input logic [OP_W-1:0] op);
        br_ctl_t c;
        c.cond     = C_NEVER;
        c.absolute = 1'b0;
        case (op)
            OPC_JREL:    c.cond = C_ALWAYS;
            OPC_JREL_EQ: c.cond = C_EQ_SET;
            OPC_JREL_NE: c.cond = C_EQ_CLR;
            OPC_JREL_NZ: c.cond = C_SRC_NZ;
            OPC_JABS_UF: begin
                c.cond     = C_UFLAG;
                c.absolute = 1'b1;
            end
            OPC_JREL_UF: c.cond = C_UFLAG;
            default:     c.cond = C_NEVER;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/relbr_sext.sv
module relbr_sext
    import relbr_pkg::*;
#(
    parameter int XLEN = DATA_W
) (
    input  logic [SZ_W-1:0] size_i,
    input  logic [XLEN-1:0] raw_i,
    output logic [XLEN-1:0] offs_o
);

    logic [XLEN-1:0] ext [NUM_SZ];

    for (genvar g = 0; g < NUM_SZ; g++) begin : g_width
        localparam int W = 8 << g;
        if (W < XLEN) begin : g_narrow
            assign ext[g] = {{(XLEN - W){raw_i[W-1]}}, raw_i[W-1:0]};
        end else begin : g_full
            assign ext[g] = raw_i;
        end
    end

    assign offs_o = ext[size_i];

endmodule

// File: rtl/relbr_cond.sv
module relbr_cond
    import relbr_pkg::*;
#(
    parameter int XLEN = DATA_W
) (
    input  cond_e           cond_i,
    input  logic [XLEN-1:0] flags_i,
    input  logic [XLEN-1:0] src_i,
    output logic            hit_o
);

    logic [NUM_UF-1:0]   uflags;
    logic [UF_IDX_W-1:0] uf_idx;

    assign uflags = flags_i[UF_BASE +: NUM_UF];
    assign uf_idx = src_i[UF_IDX_W-1:0];

    always_comb begin
        unique case (cond_i)
            C_ALWAYS: hit_o = 1'b1;
            C_EQ_SET: hit_o = flags_i[EQ_BIT];
            C_EQ_CLR: hit_o = ~flags_i[EQ_BIT];
            C_SRC_NZ: hit_o = |src_i;
            C_UFLAG:  hit_o = uflags[uf_idx];
            default:  hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/relbr_target.sv
module relbr_target
    import relbr_pkg::*;
#(
    parameter int XLEN = DATA_W
) (
    input  logic            hit_i,
    input  logic            absolute_i,
    input  logic [XLEN-1:0] ir_i,
    input  logic [XLEN-1:0] offs_i,
    input  logic [XLEN-1:0] dst_i,
    output logic [XLEN-1:0] ir_next_o
);

    logic [XLEN-1:0] rel_sum;

    assign rel_sum = ir_i + offs_i;

    always_comb begin
        if (!hit_i)          ir_next_o = ir_i;
        else if (absolute_i) ir_next_o = dst_i;
        else                 ir_next_o = rel_sum;
    end

endmodule

// File: rtl/relbr_unit.sv
module relbr_unit
    import relbr_pkg::*;
#(
    parameter int XLEN = DATA_W
) (
    input  logic [OP_W-1:0] op_i,
    input  logic [SZ_W-1:0] size_i,
    input  logic [XLEN-1:0] dst_i,
    input  logic [XLEN-1:0] src_i,
    input  logic [XLEN-1:0] flags_i,
    input  logic [XLEN-1:0] ir_i,
    output logic            take_o,
    output logic [XLEN-1:0] ir_next_o
);

    br_ctl_t         ctl;
    logic [XLEN-1:0] offs;
    logic            hit;

    assign ctl = decode_op(op_i);

    relbr_sext #(.XLEN(XLEN)) u_sext (
        .size_i (size_i),
        .raw_i  (dst_i),
        .offs_o (offs)
    );

    relbr_cond #(.XLEN(XLEN)) u_cond (
        .cond_i  (ctl.cond),
        .flags_i (flags_i),
        .src_i   (src_i),
        .hit_o   (hit)
    );

    relbr_target #(.XLEN(XLEN)) u_tgt (
        .hit_i      (hit),
        .absolute_i (ctl.absolute),
        .ir_i       (ir_i),
        .offs_i     (offs),
        .dst_i      (dst_i),
        .ir_next_o  (ir_next_o)
    );

    assign take_o = hit;

endmodule

// File: rtl/relbr_chk.sv
module relbr_chk
    import relbr_pkg::*;
#(
    parameter int XLEN = DATA_W
) (
    input logic [OP_W-1:0] op_i,
    input logic [SZ_W-1:0] size_i,
    input logic [XLEN-1:0] dst_i,
    input logic [XLEN-1:0] src_i,
    input logic [XLEN-1:0] flags_i,
    input logic [XLEN-1:0] ir_i,
    input logic            take_o,
    input logic [XLEN-1:0] ir_next_o
);

    logic known;
    logic is_branch;

    assign known = !$isunknown({op_i, size_i, dst_i, src_i, flags_i, ir_i, take_o, ir_next_o});
    assign is_branch = (op_i == OPC_JREL) || (op_i == OPC_JREL_EQ) || (op_i == OPC_JREL_NE) ||
                       (op_i == OPC_JREL_NZ) || (op_i == OPC_JABS_UF) || (op_i == OPC_JREL_UF);

    always_comb begin
        if (known) begin
            p_hold_if_not_taken_r9: assert (take_o || (ir_next_o == ir_i))
                else $error("not taken but register changed");
            p_other_op_idle_r9: assert (is_branch || !take_o)
                else $error("non-branch opcode taken");
            p_always_taken_r2: assert ((op_i != OPC_JREL) || take_o)
                else $error("unconditional jump not taken");
            p_eq_set_r3: assert ((op_i != OPC_JREL_EQ) || (take_o == flags_i[EQ_BIT]))
                else $error("equal-set jump disagrees with flag");
            p_eq_clr_r3: assert ((op_i != OPC_JREL_NE) || (take_o == !flags_i[EQ_BIT]))
                else $error("equal-clear jump disagrees with flag");
            p_src_nz_r4: assert ((op_i != OPC_JREL_NZ) || (take_o == (src_i != '0)))
                else $error("source non-zero jump wrong");
            p_uflag_sel_r5: assert (!((op_i == OPC_JABS_UF) || (op_i == OPC_JREL_UF)) ||
                                    (take_o == flags_i[UF_BASE + int'(src_i[UF_IDX_W-1:0])]))
                else $error("user flag selection wrong");
            p_abs_load_r6: assert (!((op_i == OPC_JABS_UF) && take_o) || (ir_next_o == dst_i))
                else $error("absolute target not loaded");
        end
    end

endmodule

bind relbr_unit relbr_chk #(.XLEN(XLEN)) u_chk (
    .op_i      (op_i),
    .size_i    (size_i),
    .dst_i     (dst_i),
    .src_i     (src_i),
    .flags_i   (flags_i),
    .ir_i      (ir_i),
    .take_o    (take_o),
    .ir_next_o (ir_next_o)
);

// File: tb/sim_relbr_unit.sv
module sim_relbr_unit;

    localparam int XW = 64;
    localparam int NV = 23;
    localparam logic [XW-1:0] IRB = 64'h0000_0000_0000_1000;

    typedef struct packed {
        logic [7:0]    req;
        logic [8:0]    op;
        logic [1:0]    size;
        logic [XW-1:0] dst;
        logic [XW-1:0] src;
        logic [XW-1:0] flags;
        logic [XW-1:0] ir;
        logic          exp_take;
        logic [XW-1:0] exp_ir;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        // R1/R2: each size, positive and negative, junk above the width
        '{8'd1, 9'h03C, 2'b00, 64'hABCD_0000_0000_1205, 64'h0, 64'h0, IRB, 1'b1, 64'h0000_0000_0000_1005},
        '{8'd1, 9'h03C, 2'b00, 64'h5500_0000_0000_00FB, 64'h0, 64'h0, IRB, 1'b1, 64'h0000_0000_0000_0FFB},
        '{8'd1, 9'h03C, 2'b01, 64'h1111_0000_0000_0100, 64'h0, 64'h0, IRB, 1'b1, 64'h0000_0000_0000_1100},
        '{8'd1, 9'h03C, 2'b01, 64'h0000_0000_0000_FF00, 64'h0, 64'h0, IRB, 1'b1, 64'h0000_0000_0000_0F00},
        '{8'd1, 9'h03C, 2'b10, 64'hFFFF_FFFF_0001_0000, 64'h0, 64'h0, IRB, 1'b1, 64'h0000_0000_0001_1000},
        '{8'd1, 9'h03C, 2'b10, 64'h0000_0000_FFFF_F000, 64'h0, 64'h0, IRB, 1'b1, 64'h0000_0000_0000_0000},
        '{8'd1, 9'h03C, 2'b11, 64'h0000_0001_0000_0000, 64'h0, 64'h0, IRB, 1'b1, 64'h0000_0001_0000_1000},
        '{8'd2, 9'h03C, 2'b11, 64'hFFFF_FFFF_FFFF_FFF0, 64'h0, 64'h0, IRB, 1'b1, 64'h0000_0000_0000_0FF0},
        // R3: equal flag at bit 10
        '{8'd3, 9'h03D, 2'b00, 64'h10, 64'h0, 64'h400, IRB, 1'b1, 64'h1010},
        '{8'd3, 9'h03D, 2'b00, 64'h10, 64'h0, 64'h0,   IRB, 1'b0, IRB},
        '{8'd3, 9'h03E, 2'b00, 64'h20, 64'h0, 64'h0,   IRB, 1'b1, 64'h1020},
        '{8'd3, 9'h03E, 2'b00, 64'h20, 64'h0, 64'h400, IRB, 1'b0, IRB},
        // R4: only the top source bit set
        '{8'd4, 9'h03F, 2'b00, 64'h04, 64'h8000_0000_0000_0000, 64'h0, IRB, 1'b1, 64'h1004},
        '{8'd4, 9'h03F, 2'b00, 64'h04, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, IRB, 1'b0, IRB},
        // R6: absolute load on user flag B (bit 21)
        '{8'd6, 9'h042, 2'b00, 64'hDEAD_BEEF_0000_0040, 64'h1, 64'h0020_0000, IRB, 1'b1, 64'hDEAD_BEEF_0000_0040},
        '{8'd6, 9'h042, 2'b00, 64'hDEAD_BEEF_0000_0040, 64'h1, 64'h0010_0000, IRB, 1'b0, IRB},
        // R7/R5: relative on user flag, index from low source bits
        '{8'd7, 9'h043, 2'b01, 64'h0000_0000_0000_FFFE, 64'hFFFF_FFFF_FFFF_FFFE, 64'h0040_0000, IRB, 1'b1, 64'h0FFE},
        '{8'd7, 9'h043, 2'b00, 64'h7F, 64'h3, 64'h0080_0000, IRB, 1'b1, 64'h107F},
        '{8'd5, 9'h043, 2'b00, 64'h7F, 64'h3, 64'h0070_0000, IRB, 1'b0, IRB},
        // R8: wrap both ways
        '{8'd8, 9'h03C, 2'b00, 64'h20, 64'h0, 64'h0, 64'hFFFF_FFFF_FFFF_FFF0, 1'b1, 64'h10},
        '{8'd8, 9'h03C, 2'b00, 64'hF0, 64'h0, 64'h0, 64'h8, 1'b1, 64'hFFFF_FFFF_FFFF_FFF8},
        // R9: non-branch opcodes
        '{8'd9, 9'h040, 2'b11, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, IRB, 1'b0, IRB},
        '{8'd9, 9'h03B, 2'b00, 64'h10, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, IRB, 1'b0, IRB}
    };

    logic          clk = 1'b0;
    logic [8:0]    op;
    logic [1:0]    size;
    logic [XW-1:0] dst, src, flags, ir;
    logic          take;
    logic [XW-1:0] ir_next;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    relbr_unit u0 (
        .op_i      (op),
        .size_i    (size),
        .dst_i     (dst),
        .src_i     (src),
        .flags_i   (flags),
        .ir_i      (ir),
        .take_o    (take),
        .ir_next_o (ir_next)
    );

    task automatic check(input string tag, input logic et, input logic [XW-1:0] ei);
        n_chk++;
        if (take !== et || ir_next !== ei) begin
            n_fail++;
            $display("FAIL %s: take=%0b ir=%h, expected take=%0b ir=%h", tag, take, ir_next, et, ei);
        end
    endtask

    task automatic apply(input logic [8:0] o, input logic [1:0] s, input logic [XW-1:0] d,
                         input logic [XW-1:0] sr, input logic [XW-1:0] f, input logic [XW-1:0] i);
        @(negedge clk);
        op = o; size = s; dst = d; src = sr; flags = f; ir = i;
        #1;
    endtask

    initial begin
        #200000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: expired, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        op = '0; size = '0; dst = '0; src = '0; flags = '0; ir = '0;
        // R9: idle inputs give no jump and a zero register
        apply(9'h0, 2'b00, '0, '0, '0, '0);
        check("R9 idle", 1'b0, '0);

        for (int k = 0; k < NV; k++) begin
            apply(VECS[k].op, VECS[k].size, VECS[k].dst, VECS[k].src, VECS[k].flags, VECS[k].ir);
            check($sformatf("R%0d vector %0d", VECS[k].req, k), VECS[k].exp_take, VECS[k].exp_ir);
        end

        // R5: each index with only its own flag set, then with all others set
        for (int i = 0; i < 4; i++) begin
            apply(9'h043, 2'b00, 64'h08, 64'(i) | 64'hF0, 64'(1) << (20 + i), IRB);
            check($sformatf("R5 index %0d own flag", i), 1'b1, IRB + 64'h8);
            apply(9'h043, 2'b00, 64'h08, 64'(i), 64'h00F0_0000 & ~(64'(1) << (20 + i)), IRB);
            check($sformatf("R5 index %0d other flags", i), 1'b0, IRB);
        end

        // R6: absolute target ignores the size code
        for (int s = 0; s < 4; s++) begin
            apply(9'h042, 2'(s), 64'h8000_0000_0000_00FF, 64'h0, 64'h0010_0000, IRB);
            check($sformatf("R6 size %0d", s), 1'b1, 64'h8000_0000_0000_00FF);
        end

        // R10: output follows input with no clock edge in between
        @(negedge clk);
        op = 9'h03D; size = 2'b00; dst = 64'h30; src = '0; flags = 64'h400; ir = IRB;
        #0.5;
        check("R10 first", 1'b1, 64'h1030);
        flags = 64'h0;
        #0.5;
        check("R10 after flag drop", 1'b0, IRB);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule